// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two predictors run side by side. The first is a path-based predictor: a register holds the most recent branch outcomes, and that history indexes a table of 2-bit counters. The second is a per-branch predictor: the branch address selects a record of that branch's own recent outcomes, and the record indexes a table of 3-bit counters. A chooser table of 2-bit counters sits at the same history index. It decides which of the two answers is passed on, and it learns from the cases where the two disagree.

The fetch side presents a branch address and reads the prediction combinationally in the same cycle. The resolve side later presents the branch address and its real outcome with a valid strobe. On that clock edge the counters are trained at the indices formed from the state before the edge. Both history records then shift the outcome in. With the default sizes the tables hold 4096×2 + 4096×2 + 1024×10 + 1024×3 bits.

Top module: `tourn_pred`

## Requirements
- R1: After reset, every 2-bit counter holds 01, every 3-bit counter holds 011, every history is zero and the chooser picks the per-branch side, so `pred_taken` is 0 for any address.
- R2: A 2-bit counter steps by one toward 11 on taken and toward 00 on not-taken, saturating at both ends, and predicts taken when its upper bit is 1 (values 10 and 11).
- R3: The path history is GH_W (12) bits wide. Each valid update shifts it left and places the outcome in bit 0.
- R4: The path-based answer is the upper bit of the 2-bit counter indexed by the whole path history.
- R5: Address bits [PC_LSB+LA_W-1:PC_LSB] (bits 11:2 by default) select one of 1024 per-branch histories of LH_W (10) bits. A valid update shifts the outcome into bit 0 of the selected history.
- R6: The per-branch answer is bit 2 of the 3-bit counter indexed by the selected history. That counter saturates at 000 and 111.
- R7: The chooser counter at the path-history index selects the path-based answer when its upper bit is 1. It is trained only when the two answers at update disagree: it steps up when the path-based answer was correct and down when the per-branch answer was correct.
- R8: An update trains every counter at indices formed from the history values held before that clock edge. The histories shift only at the same edge.
- R9: When `upd_valid` is 0, no state changes, whatever `upd_pc` and `upd_taken` carry.
- R10: `pred_taken` is a combinational function of `pred_pc` and the stored state. An update presented in the same cycle affects it only from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Resolved outcome present this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The prediction is compared every cycle against a behavioural model built from integer arrays.

Several stimulus patterns separate the parts of the block:
- One branch that is always taken drives the path history to all ones and walks the counters up to saturation.
- Branches with a fixed per-address period (alternating, or always not-taken) are learnable only by the per-branch side.
- Outcomes that copy the previous branch's outcome across many addresses are learnable only by the path-based side, so the chooser has to move toward it.
- Stretches with `upd_valid` low and the other update inputs toggling show that no state moves.
- A long random mix, and a short hand-computed sequence, pin down the pre-update indexing.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

    // one saturating step of an unsigned counter (width up to 8 bits)
    function automatic logic [7:0] sat_step(input logic [7:0] cur,
                                            input logic [7:0] top,
                                            input logic       up);
        logic [7:0] nxt;
        if (up)
            nxt = (cur == top) ? cur : cur + 8'd1;
        else
            nxt = (cur == 8'd0) ? cur : cur - 8'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/sat_ctr_bank.sv
module sat_ctr_bank
    import tourn_pkg::*;
#(
    parameter int                IDX_W   = 12,
    parameter int                CTR_W   = 2,
    parameter logic [CTR_W-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic             up_en,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             up_inc,
    output logic [CTR_W-1:0] up_old,
    output logic [CTR_W-1:0] up_new
);
    localparam int         DEPTH = 1 << IDX_W;
    localparam logic [7:0] TOP   = 8'((1 << CTR_W) - 1);

    logic [CTR_W-1:0] ctr_q [DEPTH];

    always_comb begin
        rd_ctr = ctr_q[rd_idx];
        up_old = ctr_q[up_idx];
        up_new = CTR_W'(sat_step(8'(up_old), TOP, up_inc));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= RST_VAL;
        end else if (up_en) begin
            ctr_q[up_idx] <= up_new;
        end
    end
endmodule

// File: rtl/local_hist_bank.sv
module local_hist_bank #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              up_en,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic              up_taken,
    output logic [HIST_W-1:0] up_hist
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist_q [DEPTH];
    logic [HIST_W-1:0] hist_d;

    always_comb begin
        rd_hist = hist_q[rd_idx];
        up_hist = hist_q[up_idx];
        hist_d  = {up_hist[HIST_W-2:0], up_taken};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
        end else if (up_en) begin
            hist_q[up_idx] <= hist_d;
        end
    end
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int GH_W   = 12,
    parameter int LA_W   = 10,
    parameter int LH_W   = 10,
    parameter int GC_W   = 2,
    parameter int LC_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam logic [GC_W-1:0] GC_WEAK_N = GC_W'(1 << (GC_W - 1)) - GC_W'(1);
    localparam logic [LC_W-1:0] LC_WEAK_N = LC_W'(1 << (LC_W - 1)) - LC_W'(1);

    typedef struct packed {
        logic [GH_W-1:0] ghist;
    } state_t;

    state_t st_d, st_q;

    logic [LA_W-1:0] lsel_pred, lsel_upd;
    logic [LH_W-1:0] lh_rd, lh_up_old;
    logic [GC_W-1:0] g_rd, g_up_old, g_up_new;
    logic [GC_W-1:0] ch_rd, ch_up_old, ch_up_new;
    logic [LC_W-1:0] l_rd, l_up_old, l_up_new;
    logic            g_upd_pred, l_upd_pred;
    logic            ch_up_en, ch_up_inc;

    // next-state and control
    always_comb begin
        lsel_pred  = pred_pc[PC_LSB +: LA_W];
        lsel_upd   = upd_pc[PC_LSB +: LA_W];

        pred_taken = ch_rd[GC_W-1] ? g_rd[GC_W-1] : l_rd[LC_W-1];

        g_upd_pred = g_up_old[GC_W-1];
        l_upd_pred = l_up_old[LC_W-1];
        ch_up_en   = upd_valid && (g_upd_pred != l_upd_pred);
        ch_up_inc  = (g_upd_pred == upd_taken);

        st_d = st_q;
        if (upd_valid)
            st_d.ghist = {st_q.ghist[GH_W-2:0], upd_taken};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // path-indexed direction counters
    sat_ctr_bank #(.IDX_W(GH_W), .CTR_W(GC_W), .RST_VAL(GC_WEAK_N)) u_gbank (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(st_q.ghist), .rd_ctr(g_rd),
        .up_en(upd_valid), .up_idx(st_q.ghist), .up_inc(upd_taken),
        .up_old(g_up_old), .up_new(g_up_new)
    );

    // chooser counters, upper half selects path-based side
    sat_ctr_bank #(.IDX_W(GH_W), .CTR_W(GC_W), .RST_VAL(GC_WEAK_N)) u_chbank (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(st_q.ghist), .rd_ctr(ch_rd),
        .up_en(ch_up_en), .up_idx(st_q.ghist), .up_inc(ch_up_inc),
        .up_old(ch_up_old), .up_new(ch_up_new)
    );

    // per-branch histories
    local_hist_bank #(.IDX_W(LA_W), .HIST_W(LH_W)) u_lhbank (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lsel_pred), .rd_hist(lh_rd),
        .up_en(upd_valid), .up_idx(lsel_upd), .up_taken(upd_taken),
        .up_hist(lh_up_old)
    );

    // per-branch direction counters
    sat_ctr_bank #(.IDX_W(LH_W), .CTR_W(LC_W), .RST_VAL(LC_WEAK_N)) u_lcbank (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lh_rd), .rd_ctr(l_rd),
        .up_en(upd_valid), .up_idx(lh_up_old), .up_inc(upd_taken),
        .up_old(l_up_old), .up_new(l_up_new)
    );
endmodule

// File: rtl/tourn_pred_chk.sv
module tourn_pred_chk #(
    parameter int GH_W = 12,
    parameter int GC_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            upd_valid,
    input logic            upd_taken,
    input logic            pred_taken,
    input logic [GH_W-1:0] ghist_q,
    input logic            ch_up_en,
    input logic            g_upd_pred,
    input logic            l_upd_pred,
    input logic [GC_W-1:0] g_up_old,
    input logic [GC_W-1:0] g_up_new
);
    assert_hist_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghist_q[GH_W-1:1] == $past(ghist_q[GH_W-2:0])) &&
                      (ghist_q[0] == $past(upd_taken)));

    assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghist_q));

    assert_chooser_disagree_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ch_up_en |-> (upd_valid && (g_upd_pred != l_upd_pred)));

    assert_gctr_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |-> (g_up_new >= g_up_old));

    assert_gctr_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |-> (g_up_new <= g_up_old));

    assert_gctr_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && (&g_up_old)) |-> (&g_up_new));

    assert_pred_known_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(pred_taken));
endmodule

bind tourn_pred tourn_pred_chk #(.GH_W(GH_W), .GC_W(GC_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_taken(upd_taken), .pred_taken(pred_taken),
    .ghist_q(st_q.ghist), .ch_up_en(ch_up_en),
    .g_upd_pred(g_upd_pred), .l_upd_pred(l_upd_pred),
    .g_up_old(g_up_old), .g_up_new(g_up_new)
);

// File: tb/test_tourn_pred.sv
module test_tourn_pred;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural model state
    int gtab [4096];
    int ctab [4096];
    int lhist[1024];
    int lctr [1024];
    int gh;

    always #5 clk = ~clk;

    tourn_pred i_tourn_pred (
        .clk(clk), .rst_n(rst_n),
        .pred_pc(pred_pc), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    function automatic int model_pred(input logic [31:0] pc);
        int li = int'((pc >> 2) & 32'h3FF);
        int gp = (gtab[gh] >= 2) ? 1 : 0;
        int lp = (lctr[lhist[li]] >= 4) ? 1 : 0;
        return (ctab[gh] >= 2) ? gp : lp;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4096; i++) begin gtab[i] = 1; ctab[i] = 1; end
        for (int i = 0; i < 1024; i++) begin lhist[i] = 0; lctr[i] = 3; end
        gh = 0;
    endtask

    task automatic model_update(input logic [31:0] pc, input int t);
        int li = int'((pc >> 2) & 32'h3FF);
        int lx = lhist[li];
        int gu = (gtab[gh] >= 2) ? 1 : 0;
        int lu = (lctr[lx] >= 4) ? 1 : 0;
        if (t != 0) begin
            if (gtab[gh] < 3) gtab[gh]++;
            if (lctr[lx] < 7) lctr[lx]++;
        end else begin
            if (gtab[gh] > 0) gtab[gh]--;
            if (lctr[lx] > 0) lctr[lx]--;
        end
        if (gu != lu) begin
            if (gu == t) begin if (ctab[gh] < 3) ctab[gh]++; end
            else         begin if (ctab[gh] > 0) ctab[gh]--; end
        end
        lhist[li] = ((lx << 1) | t) & 32'h3FF;
        gh        = ((gh << 1) | t) & 32'hFFF;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s pc=%h actual=%0d expected=%0d", tag, pred_pc, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, compare before the rising edge, then advance model
    task automatic step(input logic [31:0] ppc, input logic uv,
                        input logic [31:0] upc, input logic ut, input string tag);
        @(negedge clk);
        pred_pc   = ppc;
        upd_valid = uv;
        upd_pc    = upc;
        upd_taken = ut;
        #1;
        check(tag, int'(pred_taken), model_pred(ppc));
        @(posedge clk);
        if (uv) model_update(upc, int'(ut));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] pcs [8];
        int prev;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state predicts not-taken everywhere
        for (int i = 0; i < 16; i++) begin
            step(32'h1000 + 32'(i * 4 * 37), 1'b0, '0, 1'b0, "R1");
            checks++;
            if (pred_taken !== 1'b0) begin
                errors++;
                $display("FAIL R1 actual=%b expected=0", pred_taken);
            end
        end

        // R8/R10: hand-computed sequence, same-cycle update does not alter prediction
        step(32'h0, 1'b1, 32'h0, 1'b1, "R10");
        checks++;
        if (pred_taken !== 1'b0) begin
            errors++;
            $display("FAIL R10 actual=%b expected=0", pred_taken);
        end
        // after one taken update: chooser[1]=01 picks per-branch side, hist=1 -> counter still 011
        step(32'h0, 1'b0, 32'h0, 1'b0, "R8");
        checks++;
        if (pred_taken !== 1'b0) begin
            errors++;
            $display("FAIL R8 actual=%b expected=0", pred_taken);
        end

        // R2/R3/R4: one always-taken branch, path history saturates
        for (int i = 0; i < 40; i++)
            step(32'h40, 1'b1, 32'h40, 1'b1, "R2");
        // history all ones; predictions per model
        for (int i = 0; i < 8; i++)
            step(32'h80 + 32'(i * 4), 1'b0, '0, 1'b0, "R3");

        // R5/R6: per-branch periodic patterns
        for (int i = 0; i < 300; i++) begin
            step(32'h200, 1'b1, 32'h200, 1'(i & 1), "R5");
            step(32'h204, 1'b1, 32'h204, 1'b0, "R6");
        end

        // R4/R7: outcome copies previous outcome across many addresses
        for (int i = 0; i < 8; i++) pcs[i] = 32'h3000 + 32'(i * 4 * 113);
        prev = 1;
        for (int i = 0; i < 600; i++) begin
            int t = (i % 7 == 0) ? 1 - prev : prev;
            step(pcs[i % 8], 1'b1, pcs[i % 8], 1'(t), "R7");
            prev = t;
        end

        // R9: update strobe low, other inputs toggling
        for (int i = 0; i < 60; i++)
            step(pcs[i % 8], 1'b0, 32'($urandom), 1'(i & 1), "R9");
        for (int i = 0; i < 8; i++)
            step(pcs[i], 1'b0, '0, 1'b0, "R9");

        // R8/R10: random mix, prediction and update at different addresses
        for (int i = 0; i < 2500; i++) begin
            logic [31:0] a = 32'($urandom_range(0, 63)) << 2;
            logic [31:0] b = 32'($urandom_range(0, 63)) << 2;
            step(a, 1'($urandom_range(0, 3) != 0), b, 1'($urandom_range(0, 2) != 0), "R8");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule